// File: doc/BRIEF.md
# Test Clock Generator with Divide, Gating and Host-Driven Modes

This block makes the test clock for a test-access-port master from the system clock. In free-running mode the clock toggles without pause. In gated mode it rests low and produces whole periods only while the scan sequencer asks for activity. In host mode the clock, mode-select and data-out lines change only when the host writes new values, so any sequence can be produced for chains that do not follow the standard protocol. A 4-bit divide value sets the clock rate. A value N gives a period of 2×(N+1) system clocks with a 50% duty cycle.

Two one-cycle strobes go with the clock. The rise strobe marks the cycle in which the test clock has just gone high, which is where returning data is sampled. The fall strobe marks the cycle in which it has just gone low. The registered mode-select and data-out lines change on the fall edge. A mode change is held back until the clock is low and a half period has ended, so no shortened pulse is ever produced. All ports are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `tck_clkgen`

## Requirements
- R1: While reset is asserted and after it is released, tck_o, rise_o, fall_o, tms_o and tdo_o are 0 and mode_o reads 1 (gated).
- R2: In free-running mode (mode code 0) with divide value N held constant, tck_o stays high for N+1 cycles and then low for N+1 cycles, for every N from 0 to 15.
- R3: In gated mode (mode code 1), tck_o stays low on every cycle in which it is low and act_req_i is low.
- R4: In gated mode, when the generator is idle and act_req_i is seen high, tck_o rises at the next clock edge. Every pulse lasts N+1 cycles high, even if the request drops during the pulse. While the request stays high, the pulses repeat with N+1 cycles low between them.
- R5: rise_o is 1 exactly in the first cycle in which tck_o is high, and fall_o is 1 exactly in the first cycle in which it is low.
- R6: In host mode (mode code 2), a cycle with host_wr_i high loads host_tck_i, host_tms_i and host_tdo_i into tck_o, tms_o and tdo_o at the next edge, with the matching strobe. act_req_i, seq_tms_i and seq_tdo_i have no effect on these outputs in host mode.
- R7: In the clocked modes, tms_o and tdo_o take the values of seq_tms_i and seq_tdo_i only at the edge where tck_o falls. At every other edge they hold their value.
- R8: mode_o never changes while tck_o is high. In the clocked modes a change waits for the end of a low half period. In host mode it takes effect at the first edge at which tck_o is low.
- R9: When a pending mode change meets the edge at which a free-running clock would rise, the mode change wins: tck_o stays low, rise_o stays 0, and mode_o takes the new code.
- R10: Mode code 3 behaves exactly as gated mode, and mode_o then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Requested mode: 0 free, 1 gated, 2 host, 3 gated |
| div_i | input | 4 | Divide value N; half period is N+1 clocks |
| act_req_i | input | 1 | Sequencer activity request (gated mode) |
| host_wr_i | input | 1 | Host write strobe (host mode) |
| host_tck_i | input | 1 | Clock level written by the host |
| host_tms_i | input | 1 | Mode-select level written by the host |
| host_tdo_i | input | 1 | Data-out level written by the host |
| seq_tms_i | input | 1 | Sequencer mode-select value for the next fall |
| seq_tdo_i | input | 1 | Sequencer data-out value for the next fall |
| tck_o | output | 1 | Test clock |
| rise_o | output | 1 | One-cycle strobe: tck_o has just risen |
| fall_o | output | 1 | One-cycle strobe: tck_o has just fallen |
| tms_o | output | 1 | Registered mode-select line |
| tdo_o | output | 1 | Registered data-out line |
| mode_o | output | 2 | Mode currently in effect |

## Verification
A mode change and a rising edge of the test clock can fall on the same edge: the end of a low half period is both the only point where a clocked mode may switch and the point where a free-running clock rises. The bench provokes this by waiting for a fall strobe in free-running mode, counting out the low half period, and moving mode_i to gated on the last low cycle. It judges the outcome from the next sample: mode_o must read gated, tck_o must be low and rise_o must be 0. A second collision case is a mode request that arrives while the host holds the clock high. The bench checks that mode_o keeps the host code through the write that lowers the clock and switches one edge later.

// File: rtl/tckgen_pkg.sv
package tckgen_pkg;

  typedef enum logic [1:0] {
    TCK_FREE  = 2'd0,
    TCK_GATED = 2'd1,
    TCK_HOST  = 2'd2
  } tck_mode_e;

  // Code 3 is folded onto gated operation.
  function automatic tck_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd0:    return TCK_FREE;
      2'd2:    return TCK_HOST;
      default: return TCK_GATED;
    endcase
  endfunction

endpackage

// File: rtl/tckgen_divider.sv
module tckgen_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  input  logic             park_i,
  output logic             term_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (park_i) begin
      cnt_q <= div_i;
      lim_q <= div_i;
    end else if (restart_i) begin
      cnt_q <= '0;
      lim_q <= div_i;
    end else if (cnt_q != lim_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign term_o = (cnt_q == lim_q);

  // Half-period counter never passes the limit latched for this half
  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);

endmodule

// File: rtl/tckgen_ctrl.sv
module tckgen_ctrl
  import tckgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       act_req_i,
  input  logic       host_wr_i,
  input  logic       host_tck_i,
  input  logic       tck_i,
  input  logic       term_i,
  output logic [1:0] mode_o,
  output logic       div_restart_o,
  output logic       div_park_o,
  output logic       tck_we_o,
  output logic       tck_d_o,
  output logic       cap_seq_o,
  output logic       cap_host_o
);

  tck_mode_e mode_q;
  tck_mode_e req_mode;
  logic      switch_ok;
  logic      do_switch;

  assign req_mode  = decode_mode(mode_i);
  assign switch_ok = !tck_i && ((mode_q == TCK_HOST) || term_i);
  assign do_switch = switch_ok && (req_mode != mode_q);

  always_comb begin
    div_restart_o = 1'b0;
    div_park_o    = 1'b0;
    tck_we_o      = 1'b0;
    tck_d_o       = 1'b0;
    cap_seq_o     = 1'b0;
    cap_host_o    = 1'b0;
    if (do_switch) begin
      div_park_o = 1'b1;
    end else if (mode_q == TCK_HOST) begin
      div_park_o = 1'b1;
      if (host_wr_i) begin
        tck_we_o   = 1'b1;
        tck_d_o    = host_tck_i;
        cap_host_o = 1'b1;
      end
    end else if (term_i) begin
      if (tck_i) begin
        tck_we_o      = 1'b1;
        tck_d_o       = 1'b0;
        div_restart_o = 1'b1;
        cap_seq_o     = 1'b1;
      end else if ((mode_q == TCK_FREE) || act_req_i) begin
        tck_we_o      = 1'b1;
        tck_d_o       = 1'b1;
        div_restart_o = 1'b1;
      end else begin
        div_park_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= TCK_GATED;
    end else if (do_switch) begin
      mode_q <= req_mode;
    end
  end

  assign mode_o = mode_q;

  // Mode register holds while the clock is high
  assert_mode_hold_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_i |=> $stable(mode_q));

  // Gated mode without a request leaves the clock resting low
  assert_gated_rest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TCK_GATED && !tck_i && !act_req_i) |=> !tck_i);

  // Host mode: the clock moves only on a host write
  assert_host_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TCK_HOST && !host_wr_i) |=> $stable(tck_i));

  // Code 3 never reaches the mode register
  assert_no_code3_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);

endmodule

// File: rtl/tckgen_phase.sv
module tckgen_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);

  logic tck_q;
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= we_i && d_i && !tck_q;
      fall_q <= we_i && !d_i && tck_q;
      if (we_i) begin
        tck_q <= d_i;
      end
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_rise_marks_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (tck_q && !$past(tck_q)));

  assert_fall_marks_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!tck_q && $past(tck_q)));

  assert_strobes_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

endmodule

// File: rtl/tckgen_lines.sv
module tckgen_lines (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_seq_i,
  input  logic cap_host_i,
  input  logic seq_tms_i,
  input  logic seq_tdo_i,
  input  logic host_tms_i,
  input  logic host_tdo_i,
  output logic tms_o,
  output logic tdo_o
);

  logic tms_q;
  logic tdo_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tms_q <= 1'b0;
      tdo_q <= 1'b0;
    end else if (cap_host_i) begin
      tms_q <= host_tms_i;
      tdo_q <= host_tdo_i;
    end else if (cap_seq_i) begin
      tms_q <= seq_tms_i;
      tdo_q <= seq_tdo_i;
    end
  end

  assign tms_o = tms_q;
  assign tdo_o = tdo_q;

  assert_one_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_host_i && cap_seq_i));

endmodule

// File: rtl/tck_clkgen.sv
module tck_clkgen
  import tckgen_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             act_req_i,
  input  logic             host_wr_i,
  input  logic             host_tck_i,
  input  logic             host_tms_i,
  input  logic             host_tdo_i,
  input  logic             seq_tms_i,
  input  logic             seq_tdo_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             tms_o,
  output logic             tdo_o,
  output logic [1:0]       mode_o
);

  logic term;
  logic div_restart;
  logic div_park;
  logic tck_we;
  logic tck_d;
  logic cap_seq;
  logic cap_host;

  tckgen_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_i),
    .restart_i (div_restart),
    .park_i    (div_park),
    .term_o    (term)
  );

  tckgen_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .act_req_i     (act_req_i),
    .host_wr_i     (host_wr_i),
    .host_tck_i    (host_tck_i),
    .tck_i         (tck_o),
    .term_i        (term),
    .mode_o        (mode_o),
    .div_restart_o (div_restart),
    .div_park_o    (div_park),
    .tck_we_o      (tck_we),
    .tck_d_o       (tck_d),
    .cap_seq_o     (cap_seq),
    .cap_host_o    (cap_host)
  );

  tckgen_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tck_we),
    .d_i    (tck_d),
    .tck_o  (tck_o),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  tckgen_lines u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_seq_i  (cap_seq),
    .cap_host_i (cap_host),
    .seq_tms_i  (seq_tms_i),
    .seq_tdo_i  (seq_tdo_i),
    .host_tms_i (host_tms_i),
    .host_tdo_i (host_tdo_i),
    .tms_o      (tms_o),
    .tdo_o      (tdo_o)
  );

  // In a clocked mode, the lines move only together with a fall strobe
  assert_lines_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != TCK_HOST) ##1 !fall_o |-> ($stable(tms_o) && $stable(tdo_o)));

endmodule

// File: tb/tck_clkgen_tb_top.sv
module tck_clkgen_tb_top;

  localparam time CYC = 20ns;

  typedef struct packed {
    logic [3:0] div;
    logic [7:0] half;
  } fr_vec_t;

  // Free-running vectors: divide value and the half period it must give
  localparam fr_vec_t FREE_TBL [6] = '{
    '{4'd0,  8'd1},  '{4'd1,  8'd2},  '{4'd3,  8'd4},
    '{4'd5,  8'd6},  '{4'd9,  8'd10}, '{4'd15, 8'd16}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [3:0] div;
  logic       req, hwr, htck, htms, htdo, stms, stdo;
  logic       tck, rise, fall, tms, tdo;
  logic [1:0] mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CYC/2) clk = ~clk;

  tck_clkgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .div_i(div),
    .act_req_i(req), .host_wr_i(hwr), .host_tck_i(htck),
    .host_tms_i(htms), .host_tdo_i(htdo), .seq_tms_i(stms),
    .seq_tdo_i(stdo), .tck_o(tck), .rise_o(rise), .fall_o(fall),
    .tms_o(tms), .tdo_o(tdo), .mode_o(mode_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 200 && !rise; i++) tick();
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 200 && !fall; i++) tick();
  endtask

  task automatic wait_mode(input logic [1:0] m);
    for (int i = 0; i < 200 && mode_o != m; i++) tick();
  endtask

  // Called on a sample showing rise; measures one high and one low half
  task automatic measure(output int hi, output int lo, output int rises,
                         output bit fall_ok);
    hi = 0; lo = 0; rises = 0;
    for (int i = 0; i < 100 && tck; i++) begin
      hi++;
      if (rise) rises++;
      tick();
    end
    fall_ok = fall;
    for (int i = 0; i < 100 && !tck; i++) begin
      lo++;
      tick();
    end
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int  hi, lo, rs;
    bit  fok;
    rst_n = 1'b0; mode = 2'd1; div = 4'd0;
    req = 0; hwr = 0; htck = 0; htms = 0; htdo = 0; stms = 0; stdo = 0;
    tick(); tick(); tick();
    // R1: state during reset
    chk(tck == 0 && rise == 0 && fall == 0, "R1 clock/strobes in reset", int'(tck), 0);
    chk(mode_o == 2'd1 && tms == 0 && tdo == 0, "R1 mode/lines in reset", int'(mode_o), 1);
    rst_n = 1'b1;
    tick(); tick();
    chk(tck == 0 && mode_o == 2'd1, "R1 after release", int'(tck), 0);

    // R2/R5: free-running vectors walked from the table
    foreach (FREE_TBL[k]) begin
      div  = FREE_TBL[k].div;
      mode = 2'd0;
      wait_rise(); tick();
      wait_rise();
      chk(rise && tck, "R5 rise with first high cycle", int'(rise), 1);
      measure(hi, lo, rs, fok);
      chk(hi == int'(FREE_TBL[k].half), "R2 high half", hi, int'(FREE_TBL[k].half));
      chk(lo == int'(FREE_TBL[k].half), "R2 low half", lo, int'(FREE_TBL[k].half));
      chk(rs == 1 && fok, "R5 single rise then fall strobe", rs, 1);
    end

    // R9: mode change collides with a due rise
    div = 4'd2;
    wait_rise(); tick(); wait_rise(); tick();
    wait_fall();
    tick(); tick();
    mode = 2'd1; req = 0;
    tick();
    chk(mode_o == 2'd1, "R9 switch wins", int'(mode_o), 1);
    chk(tck == 0 && rise == 0, "R9 no rise on switch edge", int'(rise), 0);

    // R3: gated rests low
    div = 4'd1;
    tick(); tick();
    begin
      int highs = 0;
      for (int i = 0; i < 12; i++) begin tick(); if (tck) highs++; end
      chk(highs == 0, "R3 gated idle low", highs, 0);
    end

    // R4: one-cycle request gives one full pulse
    req = 1; tick(); req = 0;
    chk(tck && rise, "R4 rise next edge", int'(tck), 1);
    tick();
    chk(tck == 1, "R4 pulse kept after request drop", int'(tck), 1);
    tick();
    chk(tck == 0 && fall == 1, "R4 fall after N+1", int'(fall), 1);
    begin
      int rs2 = 0;
      for (int i = 0; i < 12; i++) begin tick(); if (rise || tck) rs2++; end
      chk(rs2 == 0, "R3 no pulse after request gone", rs2, 0);
    end

    // R4 continuous request, R7 capture on fall
    div = 4'd2; req = 1;
    wait_rise();
    stms = ~tms; stdo = ~tdo;
    begin
      logic old_tms = tms;
      tick();
      chk(tck && tms == old_tms, "R7 lines held while high", int'(tms), int'(old_tms));
      wait_fall();
      chk(tms == stms && tdo == stdo, "R7 lines taken at fall", int'(tms), int'(stms));
    end
    wait_rise();
    measure(hi, lo, rs, fok);
    chk(hi == 3 && lo == 3, "R4 repeated pulses", hi * 10 + lo, 33);
    req = 0;

    // R6/R8: host mode
    mode = 2'd2;
    wait_mode(2'd2);
    chk(mode_o == 2'd2, "R8 host mode entered", int'(mode_o), 2);
    htck = 1; htms = 1; htdo = 0; hwr = 1;
    tick(); hwr = 0;
    chk(tck && rise && tms == 1 && tdo == 0, "R6 host write", int'(tck), 1);
    mode = 2'd0; req = 1; stms = 0; stdo = 1;
    for (int i = 0; i < 6; i++) tick();
    chk(tck == 1 && tms == 1 && tdo == 0, "R6 sequencer ignored", int'(tms), 1);
    chk(rise == 0 && fall == 0, "R6 no strobes without write", int'(fall), 0);
    chk(mode_o == 2'd2, "R8 held while high", int'(mode_o), 2);
    htck = 0; htms = 0; htdo = 1; hwr = 1;
    tick(); hwr = 0; req = 0;
    chk(tck == 0 && fall && tms == 0 && tdo == 1, "R6 host lower", int'(fall), 1);
    chk(mode_o == 2'd2, "R8 not yet switched", int'(mode_o), 2);
    tick();
    chk(mode_o == 2'd0, "R8 switched once low", int'(mode_o), 0);
    tick();
    chk(tck && rise, "R2 free starts after switch", int'(rise), 1);

    // R10: code 3 is gated
    mode = 2'd3;
    wait_mode(2'd1);
    chk(mode_o == 2'd1, "R10 code 3 reads gated", int'(mode_o), 1);
    begin
      int highs = 0;
      for (int i = 0; i < 10; i++) begin tick(); if (tck) highs++; end
      chk(highs == 0, "R10 rests low like gated", highs, 0);
    end
    req = 1; tick(); req = 0;
    chk(tck && rise, "R10 request starts pulse", int'(tck), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule